// File: doc/BRIEF.md
# SIMD Branch Decision and Delay-Slot Sequencer

This unit resolves branch requests for a 16-lane SIMD core. Each request carries a 4-bit condition code, an immediate target, an optional register operand that is added to the immediate, a relative/absolute selector and the program counter of the branch. The condition is evaluated against the Z, N and C flag vectors of all lanes. The flags are reduced with "every lane" or "at least one lane" forms, each looking for either set or clear bits.

A taken branch gives a one-cycle taken pulse and a link-register write of the branch's PC + 4 in the cycle after the request. The computed target is held internally. The unit then waits while the instruction stream advances through the delay slots, which are counted as instruction-advance strobes. After the third strobe it raises a one-cycle redirect carrying the target. A new request is accepted only while the unit is idle. Requests that arrive during the delay slots or the redirect cycle are dropped.

The sequencer has three states. IDLE accepts requests, and a taken branch moves it to SHADOW. In SHADOW each strobe is counted, and the strobe that completes the slot count moves it to REDIR. REDIR presents the redirect and always returns to IDLE on the next edge. A not-taken branch leaves the unit in IDLE.

Top module: `simd_branch_unit`

## Requirements
- R1: After reset, br_taken, link_we and redirect_vld are low and the unit accepts a branch on the first cycle after reset is released.
- R2: br_cond[3:2] selects the flag vector (01 = Z, 10 = N, 11 = C). With br_cond[1:0] = 00 the branch is taken only when the selected bit is set in all 16 lanes. With 01 it is taken only when the bit is clear in all 16 lanes.
- R3: With br_cond[1:0] = 10 the branch is taken when the selected bit is set in at least one lane. With 11 it is taken when the bit is clear in at least one lane.
- R4: br_cond[3:2] = 00 means unconditional: the branch is taken whatever the flags and br_cond[1:0] are.
- R5: An accepted taken branch raises br_taken and link_we together for exactly the one cycle after the request, with link_val equal to br_pc + 4. A not-taken branch raises neither.
- R6: With br_rel = 0 the target is br_imm, plus br_reg_val when br_use_reg = 1, modulo 2^32.
- R7: With br_rel = 1 the target is the value from R6 plus br_pc + 4, modulo 2^32.
- R8: redirect_vld is high for exactly one cycle, in the cycle after the edge that samples the third inst_adv strobe. Strobes are counted from the cycle after the request. redirect_pc then equals the target and holds its value from acceptance until the redirect.
- R9: A br_valid request that arrives while a redirect is pending (delay slots or redirect cycle) is ignored. It produces no taken pulse and no link write, and it does not alter the pending redirect_pc or its timing.
- R10: A not-taken branch produces no redirect, and the unit stays ready for the next request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| br_valid | input | 1 | Branch request present this cycle |
| br_cond | input | 4 | Condition: [3:2] flag select, [1:0] reduction form |
| br_rel | input | 1 | 1 = relative target, 0 = absolute |
| br_use_reg | input | 1 | Add br_reg_val to the immediate |
| br_reg_val | input | 32 | Register operand of the target |
| br_imm | input | 32 | Immediate part of the target |
| br_pc | input | 32 | Address of the branch instruction |
| lane_z | input | 16 | Per-lane zero flags |
| lane_n | input | 16 | Per-lane negative flags |
| lane_c | input | 16 | Per-lane carry flags |
| inst_adv | input | 1 | One instruction advanced this cycle |
| br_taken | output | 1 | Pulse: accepted branch was taken |
| link_we | output | 1 | Link register write enable |
| link_val | output | 32 | Return address, branch PC + 4 |
| redirect_vld | output | 1 | One-cycle fetch redirect strobe |
| redirect_pc | output | 32 | Redirect address |

## Verification
The strict-usage assertion assumes the core never presents a branch while a redirect is pending, and the shadow-count assertion assumes inst_adv is meaningful only as a count of advancing instructions. The bench deliberately breaks the first assumption to exercise R9. It therefore builds the unit with strict usage checking turned off, and the remaining assertions hold under those overlapping requests. Stimulus spaces the strobes randomly within each delay window and places dropped requests both inside the shadow and on the redirect cycle. Flag vectors are biased toward all-ones, all-zeros and single-lane patterns so that every reduction form hits its boundary.

// File: rtl/brx_pkg.sv
package brx_pkg;

    typedef enum logic [1:0] {
        FLG_NONE = 2'b00,
        FLG_Z    = 2'b01,
        FLG_N    = 2'b10,
        FLG_C    = 2'b11
    } flag_sel_e;

    typedef enum logic [1:0] {
        FRM_ALL_SET = 2'b00,
        FRM_ALL_CLR = 2'b01,
        FRM_ANY_SET = 2'b10,
        FRM_ANY_CLR = 2'b11
    } cond_form_e;

    typedef struct packed {
        flag_sel_e  sel;
        cond_form_e form;
    } cond_code_t;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'b00,
        ST_SHADOW = 2'b01,
        ST_REDIR  = 2'b10
    } seq_state_e;

endpackage

// File: rtl/brx_flag_reduce.sv
module brx_flag_reduce
    import brx_pkg::*;
#(
    parameter int LANES = 16
) (
    input  logic [LANES-1:0] flags,
    input  cond_form_e       form,
    output logic             hit
);

    always_comb begin
        hit = 1'b0;
        unique case (form)
            FRM_ALL_SET: hit = &flags;
            FRM_ALL_CLR: hit = ~|flags;
            FRM_ANY_SET: hit = |flags;
            FRM_ANY_CLR: hit = ~&flags;
            default:     hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/brx_cond_eval.sv
module brx_cond_eval
    import brx_pkg::*;
#(
    parameter int LANES = 16
) (
    input  logic [3:0]       cond,
    input  logic [LANES-1:0] lane_z,
    input  logic [LANES-1:0] lane_n,
    input  logic [LANES-1:0] lane_c,
    output logic             take
);

    localparam int NFLAGS = 3;

    cond_code_t             code;
    logic [LANES-1:0]       fvec [NFLAGS];
    logic [NFLAGS-1:0]      hits;

    assign code    = cond_code_t'(cond);
    assign fvec[0] = lane_z;
    assign fvec[1] = lane_n;
    assign fvec[2] = lane_c;

    for (genvar k = 0; k < NFLAGS; k++) begin : g_red
        brx_flag_reduce #(.LANES(LANES)) u_red (
            .flags (fvec[k]),
            .form  (code.form),
            .hit   (hits[k])
        );
    end

    always_comb begin
        take = 1'b1;
        unique case (code.sel)
            FLG_NONE: take = 1'b1;
            FLG_Z:    take = hits[0];
            FLG_N:    take = hits[1];
            FLG_C:    take = hits[2];
            default:  take = 1'b1;
        endcase
    end

endmodule

// File: rtl/brx_target_calc.sv
module brx_target_calc #(
    parameter int AW         = 32,
    parameter int INSN_BYTES = 4
) (
    input  logic          rel,
    input  logic          use_reg,
    input  logic [AW-1:0] reg_val,
    input  logic [AW-1:0] imm,
    input  logic [AW-1:0] pc,
    output logic [AW-1:0] target,
    output logic [AW-1:0] link
);

    localparam logic [AW-1:0] STEP = AW'(INSN_BYTES);

    logic [AW-1:0] base;

    assign link   = pc + STEP;
    assign base   = imm + (use_reg ? reg_val : '0);
    assign target = rel ? (base + link) : base;

endmodule

// File: rtl/brx_slot_seq.sv
module brx_slot_seq
    import brx_pkg::*;
#(
    parameter int SLOTS = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic adv,
    output logic busy,
    output logic redirect
);

    localparam int            CW   = $clog2(SLOTS + 1);
    localparam logic [CW-1:0] LAST = CW'(SLOTS - 1);
    localparam logic [CW-1:0] FULL = CW'(SLOTS);

    seq_state_e    st_q, st_d;
    logic [CW-1:0] cnt_q, cnt_d;

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        unique case (st_q)
            ST_IDLE: begin
                if (start) begin
                    st_d  = ST_SHADOW;
                    cnt_d = '0;
                end
            end
            ST_SHADOW: begin
                if (adv) begin
                    if (cnt_q == LAST) st_d = ST_REDIR;
                    else               cnt_d = cnt_q + 1'b1;
                end
            end
            ST_REDIR: st_d = ST_IDLE;
            default:  st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    always_comb begin
        busy     = (st_q != ST_IDLE);
        redirect = (st_q == ST_REDIR);
    end

    // independent strobe tally for the slot-count check
    logic [CW-1:0] chk_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                            chk_q <= '0;
        else if (start && !busy)               chk_q <= '0;
        else if (st_q == ST_SHADOW && adv)     chk_q <= chk_q + 1'b1;
    end

    AST_REDIR_AFTER_SLOTS: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |-> (chk_q == FULL)); // R8
    AST_REDIR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |=> !redirect); // R8
    AST_START_LEAVES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (busy && !redirect)); // R8

endmodule

// File: rtl/simd_branch_unit.sv
module simd_branch_unit #(
    parameter int LANES        = 16,
    parameter int AW           = 32,
    parameter int SLOTS        = 3,
    parameter bit STRICT_USAGE = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             br_valid,
    input  logic [3:0]       br_cond,
    input  logic             br_rel,
    input  logic             br_use_reg,
    input  logic [AW-1:0]    br_reg_val,
    input  logic [AW-1:0]    br_imm,
    input  logic [AW-1:0]    br_pc,
    input  logic [LANES-1:0] lane_z,
    input  logic [LANES-1:0] lane_n,
    input  logic [LANES-1:0] lane_c,
    input  logic             inst_adv,
    output logic             br_taken,
    output logic             link_we,
    output logic [AW-1:0]    link_val,
    output logic             redirect_vld,
    output logic [AW-1:0]    redirect_pc
);

    logic          take;
    logic          busy;
    logic          accept;
    logic          start;
    logic [AW-1:0] tgt;
    logic [AW-1:0] lnk;

    brx_cond_eval #(.LANES(LANES)) u_cond (
        .cond   (br_cond),
        .lane_z (lane_z),
        .lane_n (lane_n),
        .lane_c (lane_c),
        .take   (take)
    );

    brx_target_calc #(.AW(AW)) u_tgt (
        .rel     (br_rel),
        .use_reg (br_use_reg),
        .reg_val (br_reg_val),
        .imm     (br_imm),
        .pc      (br_pc),
        .target  (tgt),
        .link    (lnk)
    );

    assign accept = br_valid && !busy;
    assign start  = accept && take;

    brx_slot_seq #(.SLOTS(SLOTS)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .adv      (inst_adv),
        .busy     (busy),
        .redirect (redirect_vld)
    );

    logic          taken_q;
    logic [AW-1:0] link_q;
    logic [AW-1:0] rpc_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            taken_q <= 1'b0;
            link_q  <= '0;
            rpc_q   <= '0;
        end else begin
            taken_q <= start;
            if (start) begin
                link_q <= lnk;
                rpc_q  <= tgt;
            end
        end
    end

    assign br_taken    = taken_q;
    assign link_we     = taken_q;
    assign link_val    = link_q;
    assign redirect_pc = rpc_q;

    AST_TAKEN_OPENS_SHADOW: assert property (@(posedge clk) disable iff (!rst_n)
        br_taken |-> (busy && !redirect_vld)); // R5
    AST_TAKEN_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        br_taken |=> !br_taken); // R5
    AST_TARGET_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (!busy || $stable(redirect_pc))); // R8
    AST_BUSY_DROPS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (br_valid && busy) |=> !br_taken); // R9

    if (STRICT_USAGE) begin : g_strict
        AST_NO_REQ_WHILE_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
            br_valid |-> !busy); // R9
    end

endmodule

// File: tb/sim_simd_branch_unit.sv
module sim_simd_branch_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        br_valid = 1'b0;
    logic [3:0]  br_cond = '0;
    logic        br_rel = 1'b0;
    logic        br_use_reg = 1'b0;
    logic [31:0] br_reg_val = '0;
    logic [31:0] br_imm = '0;
    logic [31:0] br_pc = '0;
    logic [15:0] lane_z = '0;
    logic [15:0] lane_n = '0;
    logic [15:0] lane_c = '0;
    logic        inst_adv = 1'b0;
    logic        br_taken;
    logic        link_we;
    logic [31:0] link_val;
    logic        redirect_vld;
    logic [31:0] redirect_pc;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    simd_branch_unit #(.STRICT_USAGE(1'b0)) u0 (
        .clk(clk), .rst_n(rst_n), .br_valid(br_valid), .br_cond(br_cond),
        .br_rel(br_rel), .br_use_reg(br_use_reg), .br_reg_val(br_reg_val),
        .br_imm(br_imm), .br_pc(br_pc), .lane_z(lane_z), .lane_n(lane_n),
        .lane_c(lane_c), .inst_adv(inst_adv), .br_taken(br_taken),
        .link_we(link_we), .link_val(link_val), .redirect_vld(redirect_vld),
        .redirect_pc(redirect_pc)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic bit exp_take(input logic [3:0] c, input logic [15:0] z,
                                    input logic [15:0] n, input logic [15:0] cy);
        logic [15:0] f;
        if (c[3:2] == 2'b00) return 1'b1;
        f = (c[3:2] == 2'b01) ? z : (c[3:2] == 2'b10) ? n : cy;
        case (c[1:0])
            2'b00:   return &f;
            2'b01:   return ~|f;
            2'b10:   return |f;
            default: return ~&f;
        endcase
    endfunction

    function automatic logic [31:0] exp_target(input bit rel, input bit ur,
            input logic [31:0] rv, input logic [31:0] im, input logic [31:0] pc);
        logic [31:0] b;
        b = im + (ur ? rv : 32'd0);
        return rel ? b + pc + 32'd4 : b;
    endfunction

    function automatic logic [15:0] pick_flags();
        case ($urandom % 5)
            0:       return 16'hFFFF;
            1:       return 16'h0000;
            2:       return 16'h1 << ($urandom % 16);
            3:       return ~(16'h1 << ($urandom % 16));
            default: return 16'($urandom);
        endcase
    endfunction

    // one branch with its full delay window; inj enables dropped requests (R9)
    task automatic run_branch(input logic [3:0] c, input logic [15:0] z,
            input logic [15:0] n, input logic [15:0] cy, input bit rel,
            input bit ur, input logic [31:0] rv, input logic [31:0] im,
            input logic [31:0] pc, input bit inj, input string req);
        bit          tk;
        logic [31:0] tg;
        int          seen;
        tk = exp_take(c, z, n, cy);
        tg = exp_target(rel, ur, rv, im, pc);
        @(negedge clk);
        br_valid = 1'b1; br_cond = c; lane_z = z; lane_n = n; lane_c = cy;
        br_rel = rel; br_use_reg = ur; br_reg_val = rv; br_imm = im; br_pc = pc;
        inst_adv = 1'b0;
        @(posedge clk); #1;
        check(br_taken == tk, {req, " taken"}, 32'(br_taken), 32'(tk));
        check(link_we == tk, "R5 link_we", 32'(link_we), 32'(tk));
        @(negedge clk);
        br_valid = 1'b0;
        if (!tk) begin
            for (int i = 0; i < 5; i++) begin
                inst_adv = 1'($urandom);
                @(posedge clk); #1;
                check(!redirect_vld && !br_taken, "R10 no redirect",
                      32'(redirect_vld), 32'd0);
                @(negedge clk);
            end
            inst_adv = 1'b0;
            return;
        end
        check(link_val == pc + 32'd4, "R5 link_val", link_val, pc + 32'd4);
        seen = 0;
        while (seen < 3) begin
            check(!redirect_vld, "R8 early redirect", 32'(redirect_vld), 32'd0);
            inst_adv = 1'($urandom);
            if (inj && ($urandom % 3 == 0)) begin
                br_valid = 1'b1; br_cond = 4'b0000; br_imm = 32'($urandom);
                br_pc = 32'($urandom); br_rel = 1'($urandom);
            end
            @(posedge clk); #1;
            check(!br_taken && !link_we, "R9 dropped in shadow", 32'(br_taken), 32'd0);
            if (inst_adv) seen++;
            @(negedge clk);
            br_valid = 1'b0;
        end
        inst_adv = 1'b0;
        check(redirect_vld, "R8 redirect strobe", 32'(redirect_vld), 32'd1);
        check(redirect_pc == tg, rel ? "R7 target" : "R6 target", redirect_pc, tg);
        if (inj) begin
            br_valid = 1'b1; br_cond = 4'b0000; br_imm = 32'($urandom);
        end
        @(posedge clk); #1;
        check(!redirect_vld, "R8 single cycle", 32'(redirect_vld), 32'd0);
        if (inj)
            check(!br_taken && !link_we, "R9 dropped at redirect", 32'(br_taken), 32'd0);
        @(negedge clk);
        br_valid = 1'b0;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #1;
        check(!br_taken && !link_we && !redirect_vld, "R1 reset outputs",
              {29'd0, br_taken, link_we, redirect_vld}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: accepted right away; R4 unconditional regardless of form
        run_branch(4'b0000, 16'h0, 16'h0, 16'h0, 1'b0, 1'b0, 0, 32'h100, 32'h40, 1'b0, "R4");
        run_branch(4'b0011, 16'h0, 16'h0, 16'h0, 1'b1, 1'b1, 32'h10, 32'h20, 32'h80, 1'b0, "R4");
        // R2 all-set / all-clear boundaries on each flag
        for (int s = 1; s < 4; s++) begin
            run_branch({2'(s), 2'b00}, 16'hFFFF, 16'hFFFF, 16'hFFFF, 1'b0, 1'b0, 0, 32'h200, 32'h10, 1'b0, "R2");
            run_branch({2'(s), 2'b00}, 16'hFF7F, 16'hFF7F, 16'hFF7F, 1'b0, 1'b0, 0, 32'h200, 32'h10, 1'b0, "R2");
            run_branch({2'(s), 2'b01}, 16'h0000, 16'h0000, 16'h0000, 1'b0, 1'b0, 0, 32'h300, 32'h10, 1'b0, "R2");
            run_branch({2'(s), 2'b01}, 16'h8000, 16'h8000, 16'h8000, 1'b0, 1'b0, 0, 32'h300, 32'h10, 1'b0, "R2");
            // R3 any-set / any-clear boundaries
            run_branch({2'(s), 2'b10}, 16'h0001, 16'h0001, 16'h0001, 1'b0, 1'b0, 0, 32'h400, 32'h10, 1'b0, "R3");
            run_branch({2'(s), 2'b10}, 16'h0000, 16'h0000, 16'h0000, 1'b0, 1'b0, 0, 32'h400, 32'h10, 1'b0, "R3");
            run_branch({2'(s), 2'b11}, 16'hFFFE, 16'hFFFE, 16'hFFFE, 1'b0, 1'b0, 0, 32'h500, 32'h10, 1'b0, "R3");
            run_branch({2'(s), 2'b11}, 16'hFFFF, 16'hFFFF, 16'hFFFF, 1'b0, 1'b0, 0, 32'h500, 32'h10, 1'b0, "R3");
        end
        // R2: only the selected flag matters
        run_branch(4'b0100, 16'hFFFF, 16'h0, 16'h0, 1'b0, 1'b0, 0, 32'h600, 32'h0, 1'b0, "R2");
        // R7 wraparound, R6 register plus immediate
        run_branch(4'b0000, 0, 0, 0, 1'b1, 1'b0, 0, 32'hFFFF_FFF0, 32'h20, 1'b1, "R7");
        run_branch(4'b0000, 0, 0, 0, 1'b0, 1'b1, 32'h8000_0000, 32'h8000_0010, 32'h0, 1'b1, "R6");
        // R9 with injection on every branch
        run_branch(4'b0000, 0, 0, 0, 1'b1, 1'b1, 32'h1234, 32'h40, 32'h1000, 1'b1, "R9");
        for (int i = 0; i < 300; i++) begin
            run_branch(4'($urandom), pick_flags(), pick_flags(), pick_flags(),
                       1'($urandom), 1'($urandom), 32'($urandom), 32'($urandom),
                       32'($urandom) & 32'hFFFF_FFFC, 1'($urandom), "R2 R3 random");
        end
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog R8 actual=%h expected=%h", 32'd0, 32'd1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule